// File: doc/BRIEF.md
# Prioritized Interrupt Controller

This block collects a vector of external request lines into one status register that is read and written over a small register bus. Every source has its own sense mode (level or edge), its own active polarity, and its own routing to either the normal interrupt output or the critical interrupt output. Status bits stay set until software clears them, and they reach an output only when the matching enable bit is set.

A processor reads the masked status, or the pending-number register, to find out which source to service. A level source that is still active sets its bit again as soon as it is cleared. An edge source stays latched after its input returns to the idle level. The lowest source number always wins. A few source lines are reserved and read as zero.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Request input `req_i[n]` (source n) maps to register bit 31−n in the status, enable, masked, route, polarity and trigger registers, so source 0 is the most significant bit.
- R2: Writing the status register clears every bit written as 1. Bits written as 0 keep their value.
- R3: A trigger bit of 0 makes the source level sensed. A trigger bit of 1 makes it edge sensed: one active edge sets the status bit, which then stays set until it is cleared, and a held input does not set it again.
- R4: A polarity bit of 0 means active low (falling edge in edge mode). A polarity bit of 1 means active high (rising edge in edge mode).
- R5: A route bit of 1 sends that source to `irq_norm_o`. A route bit of 0 sends it to `irq_crit_o`.
- R6: The masked register reads status AND enable. Each output is high exactly when a masked bit routed to it is set, so with enable all zero both outputs stay low.
- R7: Sources 17, 18 and 19 (register bits 14, 13, 12) are reserved: their status, enable and masked bits always read 0 and ignore writes.
- R8: When several masked sources are pending, the pending-number register reports the lowest source number.
- R9: After reset, status = 0, enable = 0, route = all ones, polarity = 0, trigger = 0, and both outputs are low.
- R10: Each request goes through a two-flop synchronizer. An input change driven before clock edge k appears in status after edge k+2.
- R11: A level source sets its status bit on every cycle its input is active, so a clear written in such a cycle has no effect.
- R12: The pending-number register holds a valid flag in bit 5 and the source number in bits 4:0. When nothing masked is pending it reads 0.
- R13: Register word addresses on `bus_addr_i`: 0 status, 1 enable, 2 route, 3 polarity, 4 trigger, 5 masked (read-only), 6 pending number (read-only). Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| req_i | input | 32 | Request lines; bit n is source n |
| bus_sel_i | input | 1 | Register access select |
| bus_we_i | input | 1 | Write strobe (with select) |
| bus_addr_i | input | 3 | Register word address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data of the addressed register |
| irq_norm_o | output | 1 | Normal interrupt request |
| irq_crit_o | output | 1 | Critical interrupt request |

## Verification
On every cycle, the assertions check the following: write-one-to-clear, no status bit falling without a status write, every detected set reaching status, the pending number pointing at the first masked bit, and both outputs staying quiet when enable is zero. Several behaviours are visible only in the bench's scenarios: the bit mapping, the synchronizer latency, the polarity and edge choices, edge latching versus a level source re-setting its bit, and routing to the two outputs. The bench covers them by sweeping every source, and by sweeping computed patterns of requests, enables and routes.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    typedef enum logic [2:0] {
        RA_STATUS = 3'd0,
        RA_ENABLE = 3'd1,
        RA_ROUTE  = 3'd2,
        RA_POLAR  = 3'd3,
        RA_TRIG   = 3'd4,
        RA_MASKED = 3'd5,
        RA_TOPID  = 3'd6
    } reg_addr_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/irq_sense.sv
module irq_sense #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_i,
    input  logic [W-1:0] polar_i,
    input  logic [W-1:0] edge_mode_i,
    output logic [W-1:0] set_o
);
    logic [W-1:0] prev_q, prev_d;
    logic [W-1:0] active, rise, fall, edge_hit;

    always_comb begin
        prev_d   = line_i;
        active   = ~(line_i ^ polar_i);
        rise     = line_i & ~prev_q;
        fall     = ~line_i & prev_q;
        edge_hit = (polar_i & rise) | (~polar_i & fall);
        set_o    = (edge_mode_i & edge_hit) | (~edge_mode_i & active);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int W   = 32,
    parameter int IDW = $clog2(W)
) (
    input  logic [W-1:0]   masked_i,
    output logic           valid_o,
    output logic [IDW-1:0] id_o
);
    always_comb begin
        id_o    = '0;
        valid_o = |masked_i;
        for (int n = W - 1; n >= 0; n--) begin
            if (masked_i[W-1-n]) id_o = IDW'(n);
        end
    end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
    import irq_ctrl_pkg::*;
#(
    parameter int          NUM_SRC  = 32,
    parameter logic [31:0] RSVD_REG = 32'h0000_7000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               bus_sel_i,
    input  logic               bus_we_i,
    input  logic [2:0]         bus_addr_i,
    input  logic [NUM_SRC-1:0] bus_wdata_i,
    output logic [NUM_SRC-1:0] bus_rdata_o,
    output logic               irq_norm_o,
    output logic               irq_crit_o
);
    localparam int IDW = $clog2(NUM_SRC);
    localparam logic [NUM_SRC-1:0] RSVD = RSVD_REG[NUM_SRC-1:0];

    typedef struct packed {
        logic [NUM_SRC-1:0] status;
        logic [NUM_SRC-1:0] enable;
        logic [NUM_SRC-1:0] route;
        logic [NUM_SRC-1:0] polar;
        logic [NUM_SRC-1:0] trig;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;

    logic [NUM_SRC-1:0] sync_src, sync_reg, set_vec, clr_vec, masked;
    logic               wr_hit, top_valid;
    logic [IDW-1:0]     top_id;

    irq_sync #(.W(NUM_SRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(req_i), .sync_o(sync_src)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_map
        assign sync_reg[NUM_SRC-1-g] = sync_src[g];
    end

    irq_sense #(.W(NUM_SRC)) u_sense (
        .clk(clk), .rst_n(rst_n), .line_i(sync_reg),
        .polar_i(cur_q.polar), .edge_mode_i(cur_q.trig), .set_o(set_vec)
    );

    assign masked = cur_q.status & cur_q.enable;

    irq_prio #(.W(NUM_SRC), .IDW(IDW)) u_prio (
        .masked_i(masked), .valid_o(top_valid), .id_o(top_id)
    );

    always_comb begin
        nxt_d   = cur_q;
        wr_hit  = bus_sel_i & bus_we_i;
        clr_vec = (wr_hit && bus_addr_i == RA_STATUS) ? bus_wdata_i : '0;
        nxt_d.status = ((cur_q.status & ~clr_vec) | set_vec) & ~RSVD;
        if (wr_hit) begin
            case (bus_addr_i)
                RA_ENABLE: nxt_d.enable = bus_wdata_i & ~RSVD;
                RA_ROUTE:  nxt_d.route  = bus_wdata_i;
                RA_POLAR:  nxt_d.polar  = bus_wdata_i;
                RA_TRIG:   nxt_d.trig   = bus_wdata_i;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q        <= '0;
            cur_q.route  <= '1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    always_comb begin
        bus_rdata_o = '0;
        case (bus_addr_i)
            RA_STATUS: bus_rdata_o = cur_q.status;
            RA_ENABLE: bus_rdata_o = cur_q.enable;
            RA_ROUTE:  bus_rdata_o = cur_q.route;
            RA_POLAR:  bus_rdata_o = cur_q.polar;
            RA_TRIG:   bus_rdata_o = cur_q.trig;
            RA_MASKED: bus_rdata_o = masked;
            RA_TOPID:  bus_rdata_o = {{(NUM_SRC-IDW-1){1'b0}}, top_valid, top_id};
            default:   bus_rdata_o = '0;
        endcase
    end

    assign irq_norm_o = |(masked & cur_q.route);
    assign irq_crit_o = |(masked & ~cur_q.route);

    AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (!rst_n) (wr_hit && bus_addr_i == RA_STATUS) |=> ((cur_q.status & $past(bus_wdata_i & ~set_vec)) == '0)); // R2
    AST_NO_SPONT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) !(wr_hit && bus_addr_i == RA_STATUS) |=> (($past(cur_q.status) & ~cur_q.status) == '0)); // R2
    AST_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n) 1'b1 |=> ((cur_q.status & $past(set_vec & ~RSVD)) == $past(set_vec & ~RSVD))); // R11
    AST_RSVD_QUIET: assert property (@(posedge clk) disable iff (!rst_n) ((cur_q.status | cur_q.enable) & RSVD) == '0); // R7
    AST_PRIO_HIT: assert property (@(posedge clk) disable iff (!rst_n) top_valid |-> masked[(NUM_SRC-1) - int'(top_id)]); // R8
    AST_PRIO_FIRST: assert property (@(posedge clk) disable iff (!rst_n) top_valid |-> ((masked >> (NUM_SRC - int'(top_id))) == '0)); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) !top_valid |-> (top_id == '0 && masked == '0)); // R12
    AST_OUT_GATED: assert property (@(posedge clk) disable iff (!rst_n) (cur_q.enable == '0) |-> (!irq_norm_o && !irq_crit_o)); // R6
endmodule

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] req = '0;
    logic        sel = 1'b0, we = 1'b0;
    logic [2:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq_norm, irq_crit;

    int checks = 0;
    int errors = 0;
    localparam logic [31:0] RSVD = 32'h0000_7000;

    always #10 clk = ~clk;

    prio_irq_ctrl dut (
        .clk(clk), .rst_n(rst_n), .req_i(req), .bus_sel_i(sel), .bus_we_i(we),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .irq_norm_o(irq_norm), .irq_crit_o(irq_crit)
    );

    function automatic logic [31:0] srcmap(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[31-i] = v[i];
        return r;
    endfunction

    function automatic logic [31:0] topid(input logic [31:0] m);
        for (int n = 0; n < 32; n++) if (m[31-n]) return 32'(32 + n);
        return 32'd0;
    endfunction

    task automatic tick(input int k);
        repeat (k) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        sel = 1'b1; we = 1'b1; addr = a; wdata = d;
        tick(1);
        we = 1'b0; sel = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        sel = 1'b1; addr = a;
        #1 d = rdata;
        sel = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic chk_reg(input string tag, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(tag, v, exp);
    endtask

    initial begin
        #(200000 * 20);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] v, pat, en, rt, st, m;
        logic rs;
        tick(2);
        rst_n = 1'b1;
        // R9 reset values (R13 addresses)
        chk_reg("R9 status", 3'd0, 32'h0);
        chk_reg("R9 enable", 3'd1, 32'h0);
        chk_reg("R9 route", 3'd2, 32'hFFFF_FFFF);
        chk_reg("R9 polar", 3'd3, 32'h0);
        chk_reg("R9 trig", 3'd4, 32'h0);
        chk("R9 outputs", {30'd0, irq_norm, irq_crit}, 32'h0);
        // R4 active-low level: idle-low inputs are pending; R7 reserved stay 0
        tick(3);
        chk_reg("R4 R7 active-low pending", 3'd0, ~RSVD);
        // R7 enable ignores reserved bits
        wr(3'd1, 32'hFFFF_FFFF);
        chk_reg("R7 enable reserved", 3'd1, ~RSVD);
        chk_reg("R12 top source 0", 3'd6, 32'd32);
        wr(3'd3, 32'hFFFF_FFFF);
        wr(3'd0, 32'hFFFF_FFFF);
        chk_reg("R2 clear all", 3'd0, 32'h0);
        chk_reg("R12 idle zero", 3'd6, 32'h0);

        // per-source sweep, level, active high
        for (int n = 0; n < 32; n++) begin
            rs = (n >= 17 && n <= 19);
            req = 32'h1 << n;
            tick(2);
            chk_reg("R10 not yet", 3'd0, 32'h0);
            tick(1);
            st = rs ? 32'h0 : (32'h1 << (31 - n));
            chk_reg("R1 R7 R10 status bit", 3'd0, st);
            chk_reg("R6 masked", 3'd5, st);
            chk_reg("R12 number", 3'd6, rs ? 32'h0 : 32'(32 + n));
            chk("R5 normal route", {30'd0, irq_norm, irq_crit}, rs ? 32'h0 : 32'h2);
            wr(3'd2, ~(32'h1 << (31 - n)));
            chk("R5 critical route", {30'd0, irq_norm, irq_crit}, rs ? 32'h0 : 32'h1);
            wr(3'd2, 32'hFFFF_FFFF);
            wr(3'd0, 32'hFFFF_FFFF);
            chk_reg("R11 level re-sets", 3'd0, st);
            req = '0;
            tick(3);
            wr(3'd0, 32'hFFFF_FFFF);
            chk_reg("R2 cleared", 3'd0, 32'h0);
        end

        // pattern sweep: priority, masking, routing
        for (int p = 1; p <= 64; p++) begin
            pat = 32'(p * 32'h9E37_79B1) ^ (32'(p) << 7);
            en  = 32'(p * 32'h85EB_CA6B) | 32'(p);
            rt  = 32'(p * 32'hC2B2_AE35);
            wr(3'd1, en);
            wr(3'd2, rt);
            req = pat;
            tick(3);
            st = srcmap(pat) & ~RSVD;
            m = st & en & ~RSVD;
            chk_reg("R1 pattern status", 3'd0, st);
            chk_reg("R6 pattern masked", 3'd5, m);
            chk_reg("R8 pattern priority", 3'd6, topid(m));
            chk("R6 pattern outputs", {30'd0, irq_norm, irq_crit}, {30'd0, |(m & rt), |(m & ~rt)});
            wr(3'd1, 32'h0);
            chk("R6 enable zero", {30'd0, irq_norm, irq_crit}, 32'h0);
            chk_reg("R6 masked zero", 3'd5, 32'h0);
            req = '0;
            tick(3);
            wr(3'd0, 32'hFFFF_FFFF);
        end

        // edge mode
        wr(3'd1, 32'hFFFF_FFFF);
        wr(3'd2, 32'hFFFF_FFFF);
        wr(3'd4, 32'hFFFF_FFFF);
        wr(3'd0, 32'hFFFF_FFFF);
        chk_reg("R3 edge start clear", 3'd0, 32'h0);
        for (int k = 0; k < 5; k++) begin
            int n;
            n = (k == 0) ? 0 : (k == 1) ? 5 : (k == 2) ? 16 : (k == 3) ? 18 : 31;
            st = (n == 18) ? 32'h0 : (32'h1 << (31 - n));
            req = 32'h1 << n;
            tick(1);
            req = '0;
            tick(4);
            chk_reg("R3 pulse latched", 3'd0, st);
            wr(3'd0, 32'hFFFF_FFFF);
            chk_reg("R3 edge cleared", 3'd0, 32'h0);
            req = 32'h1 << n;
            tick(3);
            chk_reg("R3 held edge set", 3'd0, st);
            wr(3'd0, 32'hFFFF_FFFF);
            tick(2);
            chk_reg("R3 held no re-set", 3'd0, 32'h0);
            req = '0;
            tick(3);
        end
        // R2 write-0 keeps bit: sources 1 and 2
        req = 32'h6;
        tick(1);
        req = '0;
        tick(3);
        chk_reg("R2 two latched", 3'd0, 32'h6000_0000);
        wr(3'd0, 32'h4000_0000);
        chk_reg("R2 zero keeps", 3'd0, 32'h2000_0000);
        chk_reg("R8 remaining", 3'd6, 32'd34);
        wr(3'd0, 32'hFFFF_FFFF);
        // R4 falling edge on source 3
        wr(3'd3, ~(32'h1 << 28));
        req = 32'h8;
        tick(3);
        chk_reg("R4 rising ignored", 3'd0, 32'h0);
        req = '0;
        tick(3);
        chk_reg("R4 falling sets", 3'd0, 32'h1000_0000);
        chk_reg("R12 falling number", 3'd6, 32'd35);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule